// File: doc/BRIEF.md
# Selectable-Timeout Watchdog Reset Generator

This block supervises a host processor by watching the chip-select line of a serial bus. Each chip-select pulse that stays low long enough counts as proof that the host is alive, and it restarts the watchdog count. If the count runs out first, the block drives its reset output for a fixed reset period. It then restarts the watchdog with a fresh count. After its own reset is released, the block also holds the reset output active for a power-up period before any watchdog counting starts.

A two-bit selector picks the interval:

| Selector | Interval |
|----------|----------|
| `2'b10` | shortest |
| `2'b01` | middle |
| `2'b00` | longest |
| `2'b11` | watchdog off |

Every interval, the reset period, the power-up period and the minimum pulse width are parameters counted in clock cycles. The defaults assume a 100 MHz clock: 200 ms, 600 ms and 1.4 s intervals, a 200 ms reset, a 200 ms power-up hold and a 400 ns minimum pulse. A parameter sets whether the output is active-high or active-low.

Top module: `wdog_reset_gen`

## Requirements
- R1: While `rst` is high the reset output is active. It stays active after `rst` falls, and goes inactive on clock edge POR_CYC+1 counted from the first edge that sees `rst` low.
- R2: With ACTIVE_HIGH=1 the active output level is 1. With ACTIVE_HIGH=0 the active level is 0. The two variants always drive opposite levels for the same stimulus.
- R3: Selector `2'b10` makes the output stay inactive for exactly T_SHORT cycles between reset periods when no qualified pulse arrives.
- R4: Selector `2'b01` gives exactly T_MID inactive cycles between reset periods.
- R5: Selector `2'b00` gives exactly T_LONG inactive cycles between reset periods.
- R6: Selector `2'b11` turns the watchdog off, and the output never becomes active through a timeout.
- R7: Every timeout reset period lasts exactly RST_CYC cycles. The watchdog then restarts from zero with the current selector.
- R8: A chip-select pulse (`cs_n` low, then high) is qualified when it lasts at least MIN_PULSE cycles after synchronization. A qualified pulse restarts the count, so steady pulses keep the output inactive indefinitely.
- R9: A chip-select pulse shorter than MIN_PULSE cycles is ignored, and the timeout lands exactly where it would have with no pulse.
- R10: Changing the selector while the watchdog runs restarts the count from zero using the newly selected interval.
- R11: Chip-select pulses during a reset period or the power-up period neither shorten nor extend that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| cs_n | input | 1 | Bus chip-select, active low, may be asynchronous |
| wd_sel | input | 2 | Timeout selector: 00 long, 01 middle, 10 short, 11 off |
| wdt_rst_o | output | 1 | Reset output to the host, polarity set by ACTIVE_HIGH |

## Verification
A wrong count or a wrong phase in the sequencer shows at the output as a wrongly sized inactive or active stretch. The bench therefore measures the length of each stretch on the output to the exact cycle. An error is visible no later than one full interval plus one reset period after it occurs. A wrong pulse qualifier shows as a timeout that either moves when it should not or stays put when it should move. A polarity error shows on the very first sampled cycle, because two instances with opposite polarity are compared on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        PH_POR  = 2'd0,
        PH_RUN  = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;

    typedef struct packed {
        logic kick;
        logic sel_chg;
        logic off;
    } restart_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned limit_for(input logic [1:0] sel,
                                              input int unsigned lng,
                                              input int unsigned mid,
                                              input int unsigned sht);
        case (sel)
            SEL_SHORT: return sht;
            SEL_MID:   return mid;
            default:   return lng;
        endcase
    endfunction

endpackage

// File: rtl/wdog_cs_qual.sv
module wdog_cs_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PULSE   = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    output logic kick_o
);
    localparam int unsigned WW = $clog2(MIN_PULSE + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   cs_s;
    logic                   prev_q;
    logic [WW-1:0]          width_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], cs_n};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= cs_n;
            end
        end
    endgenerate

    assign cs_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            width_q <= '0;
        end else begin
            prev_q <= cs_s;
            if (cs_s)
                width_q <= '0;
            else if (width_q != WW'(MIN_PULSE))
                width_q <= width_q + 1'b1;
        end
    end

    assign kick_o = cs_s && !prev_q && (width_q == WW'(MIN_PULSE));

    // R9
    idle_no_kick_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_s && $past(cs_s)) |-> !kick_o);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned T_LONG  = 140_000_000,
    parameter int unsigned T_MID   = 60_000_000,
    parameter int unsigned T_SHORT = 20_000_000,
    parameter int unsigned RST_CYC = 20_000_000,
    parameter int unsigned POR_CYC = 20_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kick_i,
    input  logic [1:0] sel_i,
    output logic       active_o
);
    localparam int unsigned BIG = umax(umax(T_LONG, T_MID), umax(umax(T_SHORT, RST_CYC), POR_CYC));
    localparam int unsigned CW  = $clog2(BIG + 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    sel_q;
    logic [CW-1:0] limit;
    restart_t      rs;

    assign limit      = CW'(limit_for(sel_i, T_LONG, T_MID, T_SHORT));
    assign rs.kick    = kick_i;
    assign rs.sel_chg = (sel_i != sel_q);
    assign rs.off     = (sel_i == SEL_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_POR;
            cnt_q   <= '0;
            sel_q   <= sel_i;
        end else begin
            sel_q <= sel_i;
            case (phase_q)
                PH_POR: begin
                    if (cnt_q == CW'(POR_CYC - 1)) begin
                        phase_q <= PH_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (rs.off || rs.kick || rs.sel_chg) begin
                        cnt_q <= '0;
                    end else if (cnt_q == limit - 1'b1) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == CW'(RST_CYC - 1)) begin
                        phase_q <= PH_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_POR;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign active_o = (phase_q != PH_RUN);

    // R1
    por_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_POR && cnt_q != CW'(POR_CYC - 1)) |=> (phase_q == PH_POR));

    // R7
    hold_len_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD && cnt_q == CW'(RST_CYC - 1)) |=> (phase_q == PH_RUN && cnt_q == '0));

    // R6
    off_no_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && sel_i == SEL_OFF) |=> (phase_q == PH_RUN));

    // R8
    kick_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && kick_i) |=> (phase_q == PH_RUN && cnt_q == '0));

    // R10
    sel_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && sel_i != $past(sel_i)) |=> (cnt_q == '0));

    // R11
    hold_kick_ign_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD && kick_i && cnt_q != CW'(RST_CYC - 1)) |=> (phase_q == PH_HOLD));

endmodule

// File: rtl/wdog_rst_drv.sv
module wdog_rst_drv #(
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    output logic rst_o
);
    localparam logic ON = ACTIVE_HIGH ? 1'b1 : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) rst_o <= ON;
        else     rst_o <= active_i ? ON : ~ON;
    end

    // R2
    level_on_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active_i) |=> (rst_o == ON));

endmodule

// File: rtl/wdog_reset_gen.sv
module wdog_reset_gen #(
    parameter int unsigned T_LONG      = 140_000_000,
    parameter int unsigned T_MID       = 60_000_000,
    parameter int unsigned T_SHORT     = 20_000_000,
    parameter int unsigned RST_CYC     = 20_000_000,
    parameter int unsigned POR_CYC     = 20_000_000,
    parameter int unsigned MIN_PULSE   = 40,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          ACTIVE_HIGH = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic [1:0] wd_sel,
    output logic       wdt_rst_o
);
    logic kick;
    logic active;

    wdog_cs_qual #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_PULSE  (MIN_PULSE)
    ) u_qual (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .kick_o(kick)
    );

    wdog_core #(
        .T_LONG (T_LONG),
        .T_MID  (T_MID),
        .T_SHORT(T_SHORT),
        .RST_CYC(RST_CYC),
        .POR_CYC(POR_CYC)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .kick_i  (kick),
        .sel_i   (wd_sel),
        .active_o(active)
    );

    wdog_rst_drv #(
        .ACTIVE_HIGH(ACTIVE_HIGH)
    ) u_drv (
        .clk     (clk),
        .rst     (rst),
        .active_i(active),
        .rst_o   (wdt_rst_o)
    );

endmodule

// File: tb/tb_wdog_reset_gen.sv
module tb_wdog_reset_gen;
    localparam int unsigned TS = 40;
    localparam int unsigned TM = 80;
    localparam int unsigned TL = 120;
    localparam int unsigned RC = 30;
    localparam int unsigned PC = 50;
    localparam int unsigned MP = 4;
    localparam int unsigned SY = 2;

    typedef struct packed {
        logic [1:0]  sel;
        int unsigned len;
        logic [7:0]  req;
    } vec_t;

    // req: 3 -> R3, 4 -> R4, 5 -> R5 (interval lengths per selector)
    localparam vec_t VEC [4] = '{
        '{2'b10, TS, 8'd3},
        '{2'b01, TM, 8'd4},
        '{2'b00, TL, 8'd5},
        '{2'b10, TS, 8'd3}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic [1:0] wd_sel = 2'b10;
    logic       out_lo;
    logic       out_hi;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         cyc = 0;
    bit         done = 1'b0;
    bit         mon_on = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_reset_gen #(
        .T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .RST_CYC(RC), .POR_CYC(PC),
        .MIN_PULSE(MP), .SYNC_STAGES(SY), .ACTIVE_HIGH(1'b0)
    ) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wd_sel(wd_sel), .wdt_rst_o(out_lo)
    );

    wdog_reset_gen #(
        .T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .RST_CYC(RC), .POR_CYC(PC),
        .MIN_PULSE(MP), .SYNC_STAGES(SY), .ACTIVE_HIGH(1'b1)
    ) dut_hi (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wd_sel(wd_sel), .wdt_rst_o(out_hi)
    );

    function automatic bit is_on();
        return (out_lo == 1'b0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2: the two polarities must be complementary on every sampled cycle
    always @(negedge clk) begin
        if (mon_on && (out_hi !== ~out_lo)) begin
            n_bad++;
            $display("FAIL R2 actual=%0d expected=%0d", out_hi, ~out_lo);
        end
    end

    task automatic wait_for(input bit want_on, input int limit, output int n);
        n = 0;
        while (is_on() != want_on && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse(input int unsigned len);
        cs_n = 1'b0;
        repeat (len) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        int t0;
        bit seen;

        // R1 / R2: reset state
        repeat (4) @(negedge clk);
        check(out_lo == 1'b0, "R1", out_lo, 0);
        check(out_hi == 1'b1, "R2", out_hi, 1);
        mon_on = 1'b1;
        rst = 1'b0;
        wait_for(1'b0, 1000, n);
        check(n == int'(PC + 1), "R1", n, PC + 1);

        // table walk: R3 R4 R5 interval lengths, R7 reset lengths
        for (int i = 0; i < 4; i++) begin
            wd_sel = VEC[i].sel;
            wait_for(1'b1, 1000, n);
            wait_for(1'b0, 1000, n);
            check(n == int'(RC), "R7", n, RC);
            wait_for(1'b1, 1000, n);
            check(n == int'(VEC[i].len), $sformatf("R%0d", VEC[i].req), n, VEC[i].len);
            check(out_hi == 1'b1, "R2", out_hi, 1);
        end

        // R6: watchdog off
        wait_for(1'b0, 1000, n);
        wd_sel = 2'b11;
        seen = 1'b0;
        for (int k = 0; k < int'(3 * TL); k++) begin
            @(negedge clk);
            if (is_on()) seen = 1'b1;
        end
        check(!seen, "R6", seen, 0);

        // R10: leaving off state restarts with short interval
        t0 = cyc;
        wd_sel = 2'b10;
        wait_for(1'b1, 1000, n);
        n = cyc - t0;
        check(n >= int'(TS) && n <= int'(TS + 3), "R10", n, TS + 1);

        // R8: steady qualified pulses keep output inactive
        wait_for(1'b0, 1000, n);
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            repeat (20) @(negedge clk);
            if (is_on()) seen = 1'b1;
            pulse(MP);
            if (is_on()) seen = 1'b1;
        end
        check(!seen, "R8", seen, 0);
        t0 = cyc;
        wait_for(1'b1, 1000, n);
        n = cyc - t0;
        check(n >= int'(TS) && n <= int'(TS + SY + 4), "R8", n, TS + SY + 1);

        // R9: short pulse ignored, timeout exact
        wait_for(1'b0, 1000, n);
        t0 = cyc;
        repeat (10) @(negedge clk);
        pulse(MP - 1);
        wait_for(1'b1, 1000, n);
        n = cyc - t0;
        check(n == int'(TS), "R9", n, TS);

        // R8 boundary: a pulse of exactly MIN_PULSE delays the timeout
        wait_for(1'b0, 1000, n);
        t0 = cyc;
        repeat (10) @(negedge clk);
        pulse(MP);
        wait_for(1'b1, 1000, n);
        n = cyc - t0;
        check(n > int'(TS), "R8", n, TS + 1);

        // R11: pulse during reset period leaves its length unchanged
        t0 = cyc;
        repeat (5) @(negedge clk);
        pulse(MP + 2);
        wait_for(1'b0, 1000, n);
        n = cyc - t0;
        check(n == int'(RC), "R11", n, RC);

        // R10: selector change mid-run restarts count with new interval
        wd_sel = 2'b00;
        wait_for(1'b1, 1000, n);
        wait_for(1'b0, 1000, n);
        t0 = cyc;
        repeat (20) @(negedge clk);
        wd_sel = 2'b10;
        wait_for(1'b1, 1000, n);
        n = cyc - t0;
        check(n >= int'(20 + TS - 1) && n <= int'(20 + TS + 2), "R10", n, 20 + TS);

        // R1 again: re-applied reset activates output and restarts power-up hold
        wait_for(1'b0, 1000, n);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(out_lo == 1'b0, "R1", out_lo, 0);
        rst = 1'b0;
        pulse(MP + 1);
        wait_for(1'b0, 1000, n);
        check(n == int'(PC + 1 - (MP + 1)), "R11", n, PC + 1 - (MP + 1));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule